// File: doc/BRIEF.md
# ADC Channel Sample-Phase Sequencer

This block times one channel conversion of a successive-approximation converter, in converter-clock cycles. A start pulse captures a channel number and the phase settings. The block then steps through an optional discharge phase, a sampling window and a conversion phase, and ends with a done pulse. During discharge the core input multiplexer is steered to the low reference instead of the channel pin, so the sampling capacitor is emptied before the new sample is taken. The conversion itself is modelled as a fixed busy period.

All pins are plain control and status signals. The request side has no back-pressure. A start pulse that arrives while a conversion is under way is dropped, and the `busy` output tells the requester when a new start will be accepted. Channel, discharge enable and both cycle counts are captured on the accepted start. Changing them later has no effect on the conversion already running.

Top module: `adc_phase_seq`

## Requirements
- R1: While reset is held and after its release, before any start, `busy`, `lowref_sel`, `samp_en`, `conv_strobe` and `done` are all 0.
- R2: A start sampled high while `busy` is 0 makes `busy` 1 from the next cycle until the cycle of `done`, inclusive. `busy` is 0 in the cycle after `done`.
- R3: A start sampled high while `busy` is 1 is ignored. This includes the `done` cycle. The phase timing, the channel output and the return to idle are unchanged.
- R4: With the discharge enable 1 at start, `lowref_sel` is 1 and `samp_en` is 0 for exactly D cycles, beginning in the cycle after start.
- R5: The discharge count is 8 bits wide. D equals the count, except that a count of 0 gives D = 1.
- R6: With the discharge enable 0 at start, `samp_en` rises in the cycle right after start and `lowref_sel` stays 0.
- R7: The sampling window follows the discharge phase directly. It lasts S = max(sample count, 2) cycles.
- R8: The conversion phase follows sampling directly and lasts 12 cycles. `conv_strobe` is 1 only in its first cycle.
- R9: `done` is a single-cycle pulse in the cycle after the 12th conversion cycle.
- R10: `chan_sel` shows the channel captured at start and stays unchanged while `busy` is 1.
- R11: Changes to the channel, discharge enable, discharge count or sample count while `busy` is 1 do not alter the running conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, sampled each cycle |
| chan_in | input | CH_W | Channel to convert |
| dis_en | input | 1 | Enable the discharge phase |
| dis_cyc | input | DIS_W | Discharge length in cycles (0 means 1) |
| samp_cyc | input | SAMP_W | Sampling window length in cycles (minimum 2) |
| chan_sel | output | CH_W | Captured channel for the input multiplexer |
| lowref_sel | output | 1 | Multiplexer steered to the low reference |
| samp_en | output | 1 | Sample switch closed |
| conv_strobe | output | 1 | First cycle of the conversion phase |
| done | output | 1 | Conversion finished, one cycle |
| busy | output | 1 | Conversion in progress |

## Verification
On every cycle the assertions check the following. Discharge and sampling never overlap. Sampling follows discharge directly, and the strobe follows sampling directly. Each sampling window is at least two cycles long. Exactly twelve conversion cycles come before `done`. `done` is one cycle long and always ends `busy`. The channel output stays stable while busy. The exact discharge and sampling lengths for a given setting, the zero-count discharge case, and the dropping of late starts and mid-run setting changes all depend on values captured at start. Only the bench's sweep over discharge enable, discharge count, sample count and channel can show these.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DIS  = 3'd1,
    PH_SAMP = 3'd2,
    PH_CONV = 3'd3,
    PH_DONE = 3'd4
  } phase_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/adc_seq_timer.sv
// Down-counter shared by all timed phases; expired marks the last cycle.
module adc_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_seq_capture.sv
// Captures channel and sampling length at an accepted start.
module adc_seq_capture #(
  parameter int CH_W     = 4,
  parameter int SAMP_W   = 8,
  parameter int SAMP_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [CH_W-1:0]   chan_in,
  input  logic [SAMP_W-1:0] samp_cyc,
  output logic [CH_W-1:0]   chan_q,
  output logic [SAMP_W-1:0] samp_m1_now,
  output logic [SAMP_W-1:0] samp_m1_q
);
  localparam logic [SAMP_W-1:0] MIN_V = SAMP_W'(SAMP_MIN);

  always_comb begin
    if (samp_cyc < MIN_V) samp_m1_now = MIN_V - 1'b1;
    else                  samp_m1_now = samp_cyc - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q    <= '0;
      samp_m1_q <= '0;
    end else if (capture) begin
      chan_q    <= chan_in;
      samp_m1_q <= samp_m1_now;
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
// Phase walker: idle -> [discharge] -> sample -> convert -> done.
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DIS_W    = 8,
  parameter int SAMP_W   = 8,
  parameter int CONV_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dis_en,
  input  logic [DIS_W-1:0]  dis_cyc,
  input  logic [SAMP_W-1:0] samp_m1_now,
  input  logic [SAMP_W-1:0] samp_m1_q,
  input  logic              expired,
  output phase_e            phase,
  output logic              accept,
  output logic              load,
  output logic [CNT_W-1:0]  load_val
);
  phase_e           nxt;
  logic [DIS_W-1:0] dis_m1;

  assign accept = (phase == PH_IDLE) && start;
  assign dis_m1 = (dis_cyc == '0) ? '0 : dis_cyc - 1'b1;

  always_comb begin
    nxt      = phase;
    load     = 1'b0;
    load_val = '0;
    unique case (phase)
      PH_IDLE: if (start) begin
        load = 1'b1;
        if (dis_en) begin
          nxt      = PH_DIS;
          load_val = CNT_W'(dis_m1);
        end else begin
          nxt      = PH_SAMP;
          load_val = CNT_W'(samp_m1_now);
        end
      end
      PH_DIS: if (expired) begin
        nxt      = PH_SAMP;
        load     = 1'b1;
        load_val = CNT_W'(samp_m1_q);
      end
      PH_SAMP: if (expired) begin
        nxt      = PH_CONV;
        load     = 1'b1;
        load_val = CNT_W'(CONV_CYC - 1);
      end
      PH_CONV: if (expired) nxt = PH_DONE;
      PH_DONE: nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_W     = 4,
  parameter int DIS_W    = 8,
  parameter int SAMP_W   = 8,
  parameter int SAMP_MIN = 2,
  parameter int CONV_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   chan_in,
  input  logic              dis_en,
  input  logic [DIS_W-1:0]  dis_cyc,
  input  logic [SAMP_W-1:0] samp_cyc,
  output logic [CH_W-1:0]   chan_sel,
  output logic              lowref_sel,
  output logic              samp_en,
  output logic              conv_strobe,
  output logic              done,
  output logic              busy
);
  localparam int CONV_W = $clog2(CONV_CYC + 1);
  localparam int CNT_W  = int'(max_u(max_u(DIS_W, SAMP_W), CONV_W));

  phase_e            phase;
  logic              accept, load, expired;
  logic [CNT_W-1:0]  load_val, cnt;
  logic [SAMP_W-1:0] samp_m1_now, samp_m1_q;

  adc_seq_capture #(.CH_W(CH_W), .SAMP_W(SAMP_W), .SAMP_MIN(SAMP_MIN)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(accept), .chan_in(chan_in),
    .samp_cyc(samp_cyc), .chan_q(chan_sel), .samp_m1_now(samp_m1_now),
    .samp_m1_q(samp_m1_q)
  );

  adc_seq_fsm #(.CNT_W(CNT_W), .DIS_W(DIS_W), .SAMP_W(SAMP_W), .CONV_CYC(CONV_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .dis_en(dis_en), .dis_cyc(dis_cyc),
    .samp_m1_now(samp_m1_now), .samp_m1_q(samp_m1_q), .expired(expired),
    .phase(phase), .accept(accept), .load(load), .load_val(load_val)
  );

  adc_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .cnt(cnt), .expired(expired)
  );

  assign busy        = (phase != PH_IDLE);
  assign lowref_sel  = (phase == PH_DIS);
  assign samp_en     = (phase == PH_SAMP);
  assign conv_strobe = (phase == PH_CONV) && (cnt == CNT_W'(CONV_CYC - 1));
  assign done        = (phase == PH_DONE);
endmodule

// File: rtl/adc_phase_seq_chk.sv
module adc_phase_seq_chk #(
  parameter int CH_W     = 4,
  parameter int CONV_CYC = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [CH_W-1:0] chan_sel,
  input logic            lowref_sel,
  input logic            samp_en,
  input logic            conv_strobe,
  input logic            done,
  input logic            busy
);
  localparam int CW = $clog2(CONV_CYC + 2);
  logic [CW-1:0] conv_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           conv_seen <= '0;
    else if (conv_strobe) conv_seen <= CW'(1);
    else if (busy && !done && conv_seen != '0) conv_seen <= conv_seen + 1'b1;
    else if (!busy)       conv_seen <= '0;
  end

  a_r2_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r2_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  a_r3_no_restart_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r4_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lowref_sel && samp_en));
  a_r7_samp_after_dis: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lowref_sel) |-> samp_en);
  a_r7_samp_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(samp_en) |-> $past(samp_en, 2));
  a_r8_strobe_after_samp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(samp_en) |-> conv_strobe);
  a_r9_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (conv_seen == CW'(CONV_CYC)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_chan_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chan_sel));
endmodule

bind adc_phase_seq adc_phase_seq_chk #(.CH_W(CH_W), .CONV_CYC(CONV_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
  .lowref_sel(lowref_sel), .samp_en(samp_en), .conv_strobe(conv_strobe),
  .done(done), .busy(busy)
);

// File: tb/tb_adc_phase_seq.sv
module tb_adc_phase_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] chan_in = '0;
  logic       dis_en = 1'b0;
  logic [7:0] dis_cyc = '0;
  logic [7:0] samp_cyc = '0;
  logic [3:0] chan_sel;
  logic       lowref_sel, samp_en, conv_strobe, done, busy;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  adc_phase_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_in(chan_in), .dis_en(dis_en),
    .dis_cyc(dis_cyc), .samp_cyc(samp_cyc), .chan_sel(chan_sel),
    .lowref_sel(lowref_sel), .samp_en(samp_en), .conv_strobe(conv_strobe),
    .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] outs();
    return {lowref_sel, samp_en, conv_strobe, done, busy};
  endfunction

  // One conversion; checks every cycle against arithmetic expectations.
  task automatic run(input bit en, input int dc, input int sc, input logic [3:0] ch);
    int n, s, t;
    logic [4:0] ex;
    string tag;
    n = en ? ((dc == 0) ? 1 : dc) : 0;
    s = (sc < 2) ? 2 : sc;
    t = n + s + 12 + 1;
    @(negedge clk);
    start = 1'b1; chan_in = ch; dis_en = en;
    dis_cyc = 8'(dc); samp_cyc = 8'(sc);
    for (int i = 0; i <= t; i++) begin
      @(negedge clk);
      // R11: scramble settings while busy; R3: extra starts while busy
      start    = (i == 2) || (i == t - 1);
      chan_in  = ~ch;
      dis_en   = ~en;
      dis_cyc  = 8'(dc + 3);
      samp_cyc = 8'(sc + 5);
      if (i == t) begin
        chk(outs() == 5'b0, "R2/R3 idle after done", int'(outs()), 0);
      end else begin
        if (i < n)               begin ex = 5'b10001; tag = "R4/R5/R11 discharge"; end
        else if (i < n + s)      begin ex = 5'b01001; tag = (n == 0) ? "R6/R7 sample" : "R7/R11 sample"; end
        else if (i == n + s)     begin ex = 5'b00101; tag = "R8 strobe"; end
        else if (i < t - 1)      begin ex = 5'b00001; tag = "R8 convert"; end
        else                     begin ex = 5'b00011; tag = "R9 done"; end
        chk(outs() == ex, tag, int'(outs()), int'(ex));
        chk(chan_sel == ch, "R10 channel held", int'(chan_sel), int'(ch));
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R3 late start ignored", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    int dcs[6] = '{0, 1, 2, 3, 5, 255};
    int scs[5] = '{0, 1, 2, 3, 7};
    repeat (3) @(negedge clk);
    chk(outs() == 5'b0, "R1 outputs in reset", int'(outs()), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outs() == 5'b0, "R1 idle after reset", int'(outs()), 0);
    k = 0;
    for (int e = 0; e < 2; e++)
      for (int d = 0; d < 6; d++)
        for (int s = 0; s < 5; s++) begin
          if (e == 0 && d > 0) continue;
          run(e[0], dcs[d], scs[s], 4'(k * 5 + 3));
          k++;
        end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule